// File: doc/BRIEF.md
# Reset and Power-Down Wake Sequencer

This block decides when a small controller core may run. It watches two digital supply indications: supply above the power-on level, and supply above the brown-out level. It also watches an active-high external reset pin and an active-low external interrupt pin. From these it drives four things: the internal reset, a clock enable for the CPU, an enable for the oscillator, and a cold-start flag that software can read and write.

Leaving reset is always delayed by a start-up timeout. The timeout is a parameter counted in oscillator ticks and stands for a nominal 2 ms. The CPU requests power-down, and the sequencer grants it only after a short guard window in the run state. It then gates the core clock and stops the oscillator.

Power-down ends in one of two ways. An enabled, level-configured interrupt can end it: a mode input then selects either the same timeout or release on the rising edge of the interrupt pin. A rising edge on the reset pin can also end it, which behaves like a timed wake followed by reset.

Top module: `pws_seq`

## Requirements
- R1: `osc_en` is low whenever `por_ok` is low and while `rst_n` is low. It goes high at the first clock edge that samples `por_ok` high.
- R2: Start-up from the power-off state with both supply indications high: `sys_rst` falls and `cpu_clk_en` rises at the (DELAY_TICKS+2)-th edge. After a brown-out, the release comes at the (DELAY_TICKS+1)-th edge, counted from the first edge that samples `bod_ok` high again.
- R3: If `por_ok` or `bod_ok` falls, `sys_rst` goes high and `cpu_clk_en` goes low in the same cycle, with no clock edge needed. Reset then stays asserted and the start-up timeout restarts.
- R4: The reset pin takes effect only after it is sampled high on RST_HOLD = 2*MC_TICKS consecutive edges. A shorter pulse has no effect. A valid pulse raises `sys_rst` at edge RST_HOLD+1, and `sys_rst` is released at the first edge that samples the pin low.
- R5: `cold_flag` is 1 after `rst_n` and is set again whenever `por_ok` is low. Brown-out and pin resets leave it unchanged. `cold_wr` loads `cold_wdata` into it while `cpu_clk_en` is high.
- R6: In power-down, with `irq_wake_en` high, a falling edge on `irq_n` raises `osc_en` at the edge that samples the low level. With `irq_wake_en` low, that falling edge is ignored and the block stays in power-down.
- R7: Timed wake (`wake_ext_mode`=0): `cpu_clk_en` rises at the (DELAY_TICKS+1)-th edge, counting the wake edge as the first. In the same cycle `wake_irq` pulses high for one cycle, marking the start of the interrupt handler.
- R8: External wake (`wake_ext_mode`=1): `cpu_clk_en` stays low for as long as `irq_n` is held low, however long that is. It rises, together with a `wake_irq` pulse, at the first edge that samples `irq_n` high again.
- R9: In power-down, a rising edge on `ext_rst` turns the oscillator on and holds `sys_rst` high. The release comes one edge after the later of two events: DELAY_TICKS edges have elapsed, or the pin is sampled low. For a short pulse, `sys_rst` falls at edge DELAY_TICKS+2.
- R10: `pd_req` is obeyed only in the run state and only once PD_GUARD_TICKS edges have passed since the run state was entered. Earlier requests are ignored. When a request is obeyed, `cpu_clk_en` and `osc_en` fall at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_ok | input | 1 | Supply is above the power-on level |
| bod_ok | input | 1 | Supply is above the brown-out level |
| ext_rst | input | 1 | External reset pin, active high |
| irq_n | input | 1 | External interrupt pin, active low |
| irq_wake_en | input | 1 | Interrupt is enabled and level-configured for wake |
| wake_ext_mode | input | 1 | 0: timed wake, 1: wake released by interrupt pin rise |
| pd_req | input | 1 | Power-down request from the CPU |
| cold_wr | input | 1 | Software write strobe for the cold-start flag |
| cold_wdata | input | 1 | Value written to the cold-start flag |
| sys_rst | output | 1 | Internal reset, active high |
| cpu_clk_en | output | 1 | Clock enable to the CPU |
| osc_en | output | 1 | Oscillator enable |
| cold_flag | output | 1 | Cold-start (power-off) flag |
| wake_irq | output | 1 | One-cycle pulse when the CPU resumes from an interrupt wake |

## Verification
The hardest point to reach from the ports is the guard window that blocks power-down right after the run state starts. The window reopens on every run entry, so each probe first needs a full power-down and wake round trip. The bench sweeps the offset of a single-cycle request across the window. After each probe it wakes the block, alternating between the timed and external styles, so each pass also checks both wake timings from a fresh power-down. A second sweep varies the reset-pin pulse length across the hold threshold and records the edge at which the internal reset first appears.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_BODWAIT = 4'd1,
    ST_PORDLY  = 4'd2,
    ST_RUN     = 4'd3,
    ST_PINRST  = 4'd4,
    ST_PD      = 4'd5,
    ST_WAKE_T  = 4'd6,
    ST_WAKE_X  = 4'd7,
    ST_PDRST   = 4'd8
  } pws_state_e;

endpackage

// File: rtl/pws_hold_filter.sv
module pws_hold_filter #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic held
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(HOLD)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign held = (cnt_q == CW'(HOLD));
endmodule

// File: rtl/pws_delay_timer.sv
module pws_delay_timer #(
  parameter int LEN = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == CW'(LEN - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (run && !done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pws_guard_timer.sv
module pws_guard_timer #(
  parameter int LEN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CW'(LEN);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pws_seq.sv
module pws_seq #(
  parameter int MC_TICKS       = 12,
  parameter int DELAY_TICKS    = 24000,
  parameter int PD_GUARD_TICKS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic bod_ok,
  input  logic ext_rst,
  input  logic irq_n,
  input  logic irq_wake_en,
  input  logic wake_ext_mode,
  input  logic pd_req,
  input  logic cold_wr,
  input  logic cold_wdata,
  output logic sys_rst,
  output logic cpu_clk_en,
  output logic osc_en,
  output logic cold_flag,
  output logic wake_irq
);
  import pws_pkg::*;

  localparam int RST_HOLD = 2 * MC_TICKS;

  pws_state_e st_q, st_d;
  logic       ext_q, irq_q;
  logic       pin_held, dly_done, guard_ok;
  logic       dly_run, dly_clear, guard_start;
  logic       supply_ok, irq_fall, irq_rise, ext_rise;
  logic       wake_d, cold_d;

  assign supply_ok = por_ok && bod_ok;
  assign irq_fall  = irq_q && !irq_n;
  assign irq_rise  = !irq_q && irq_n;
  assign ext_rise  = !ext_q && ext_rst;

  pws_hold_filter #(.HOLD(RST_HOLD)) u_pin_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_rst),
    .held (pin_held)
  );

  pws_delay_timer #(.LEN(DELAY_TICKS)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(dly_clear),
    .run  (dly_run),
    .done (dly_done)
  );

  pws_guard_timer #(.LEN(PD_GUARD_TICKS)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (guard_start),
    .expired(guard_ok)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    if (!por_ok) begin
      st_d = ST_OFF;
    end else if (!bod_ok) begin
      st_d = ST_BODWAIT;
    end else begin
      unique case (st_q)
        ST_OFF:     st_d = ST_BODWAIT;
        ST_BODWAIT: st_d = ST_PORDLY;
        ST_PORDLY:  if (dly_done) st_d = ST_RUN;
        ST_RUN: begin
          if (pin_held)               st_d = ST_PINRST;
          else if (pd_req && guard_ok) st_d = ST_PD;
        end
        ST_PINRST:  if (!ext_rst) st_d = ST_RUN;
        ST_PD: begin
          if (ext_rise)                     st_d = ST_PDRST;
          else if (irq_wake_en && irq_fall) st_d = wake_ext_mode ? ST_WAKE_X : ST_WAKE_T;
        end
        ST_WAKE_T: begin
          if (pin_held)      st_d = ST_PINRST;
          else if (dly_done) st_d = ST_RUN;
        end
        ST_WAKE_X: begin
          if (pin_held)      st_d = ST_PINRST;
          else if (irq_rise) st_d = ST_RUN;
        end
        ST_PDRST:   if (dly_done) st_d = ST_PINRST;
        default:    st_d = ST_OFF;
      endcase
    end
  end

  assign dly_clear   = (st_d != st_q);
  assign dly_run     = (st_q == ST_PORDLY) || (st_q == ST_WAKE_T) || (st_q == ST_PDRST);
  assign guard_start = (st_d == ST_RUN) && (st_q != ST_RUN);
  assign wake_d      = (st_d == ST_RUN) && ((st_q == ST_WAKE_T) || (st_q == ST_WAKE_X));

  always_comb begin
    cold_d = cold_flag;
    if (!por_ok)                     cold_d = 1'b1;
    else if (cold_wr && cpu_clk_en)  cold_d = cold_wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OFF;
      ext_q     <= 1'b0;
      irq_q     <= 1'b1;
      wake_irq  <= 1'b0;
      cold_flag <= 1'b1;
    end else begin
      st_q      <= st_d;
      ext_q     <= ext_rst;
      irq_q     <= irq_n;
      wake_irq  <= wake_d;
      cold_flag <= cold_d;
    end
  end

  // outputs: state-based, with immediate override on supply loss
  always_comb begin
    sys_rst    = 1'b1;
    cpu_clk_en = 1'b0;
    osc_en     = por_ok && (st_q != ST_OFF) && (st_q != ST_PD);
    unique case (st_q)
      ST_RUN:                      begin sys_rst = !supply_ok; cpu_clk_en = supply_ok; end
      ST_PD, ST_WAKE_T, ST_WAKE_X: sys_rst = !supply_ok;
      default:                     sys_rst = 1'b1;
    endcase
  end
endmodule

// File: rtl/pws_seq_chk.sv
module pws_seq_chk #(
  parameter int GUARD = 48
) (
  input logic clk,
  input logic rst_n,
  input logic por_ok,
  input logic bod_ok,
  input logic cold_wr,
  input logic cold_wdata,
  input logic sys_rst,
  input logic cpu_clk_en,
  input logic osc_en,
  input logic cold_flag,
  input logic wake_irq
);
  localparam int RW = $clog2(GUARD + 2) + 1;

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_cnt <= '0;
    else if (!cpu_clk_en)          run_cnt <= '0;
    else if (run_cnt != {RW{1'b1}}) run_cnt <= run_cnt + 1'b1;
  end

  a_r1_osc_needs_por: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> por_ok && $past(por_ok));

  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> por_ok && bod_ok && $past(por_ok) && $past(bod_ok));

  a_r3_loss_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bod_ok) && por_ok) |=> (sys_rst && !cpu_clk_en));

  a_r5_cold_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_flag) |-> ($past(!por_ok) || $past(cold_wr && cold_wdata)));

  a_r7_wake_runs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && por_ok && bod_ok) |-> (cpu_clk_en && !sys_rst));

  a_r10_guard_respected: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(osc_en) && por_ok) |-> (!cpu_clk_en && (run_cnt >= RW'(GUARD + 1))));
endmodule

bind pws_seq pws_seq_chk #(.GUARD(PD_GUARD_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_ok    (por_ok),
  .bod_ok    (bod_ok),
  .cold_wr   (cold_wr),
  .cold_wdata(cold_wdata),
  .sys_rst   (sys_rst),
  .cpu_clk_en(cpu_clk_en),
  .osc_en    (osc_en),
  .cold_flag (cold_flag),
  .wake_irq  (wake_irq)
);

// File: tb/pws_seq_bench.sv
`timescale 1ns/1ps
module pws_seq_bench;
  localparam int MC = 2;
  localparam int D  = 10;
  localparam int G  = 5;
  localparam int HOLD = 2 * MC;

  logic clk = 1'b0;
  logic rst_n, por_ok, bod_ok, ext_rst, irq_n, irq_wake_en, wake_ext_mode;
  logic pd_req, cold_wr, cold_wdata;
  logic sys_rst, cpu_clk_en, osc_en, cold_flag, wake_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pws_seq #(.MC_TICKS(MC), .DELAY_TICKS(D), .PD_GUARD_TICKS(G)) u_pws_seq (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .bod_ok(bod_ok),
    .ext_rst(ext_rst), .irq_n(irq_n), .irq_wake_en(irq_wake_en),
    .wake_ext_mode(wake_ext_mode), .pd_req(pd_req), .cold_wr(cold_wr),
    .cold_wdata(cold_wdata), .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .cold_flag(cold_flag), .wake_irq(wake_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // which: 0 -> until sys_rst low, 1 -> until cpu_clk_en high
  task automatic edges_until(input int which, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (((which == 0) ? sys_rst : !cpu_clk_en) && n < 200);
  endtask

  task automatic enter_pd();
    pd_req = 1'b1;
    for (int i = 0; i < 50 && osc_en; i++) step();
    pd_req = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int bad;
    int first_hi;
    rst_n = 1'b0; por_ok = 1'b0; bod_ok = 1'b0; ext_rst = 1'b0; irq_n = 1'b1;
    irq_wake_en = 1'b1; wake_ext_mode = 1'b0; pd_req = 1'b0;
    cold_wr = 1'b0; cold_wdata = 1'b0;
    repeat (2) @(negedge clk);
    chk(sys_rst && !cpu_clk_en && !osc_en, "R1 reset state", {sys_rst, cpu_clk_en, osc_en}, 4);
    chk(cold_flag == 1'b1 && wake_irq == 1'b0, "R5 reset cold flag", cold_flag, 1);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!osc_en, "R1 osc off without por", osc_en, 0);
    por_ok = 1'b1;
    step();
    chk(osc_en && sys_rst, "R1 osc on after por", osc_en, 1);
    repeat (3) step();
    chk(sys_rst, "R2 reset held without bod", sys_rst, 1);
    bod_ok = 1'b1;
    edges_until(0, n);
    chk(n == D + 1, "R2 release after bod", n, D + 1);
    chk(cpu_clk_en, "R2 clock enabled on release", cpu_clk_en, 1);

    // guard sweep with alternating wake styles
    for (int o = 0; o <= G + 2; o++) begin
      repeat (o) step();
      pd_req = 1'b1;
      step();
      chk(osc_en == ((o >= G) ? 1'b0 : 1'b1), "R10 guard window", osc_en, (o >= G) ? 0 : 1);
      chk(cpu_clk_en == osc_en, "R10 clk and osc drop together", cpu_clk_en, osc_en);
      pd_req = 1'b0;
      if (osc_en) enter_pd();
      wake_ext_mode = o[0];
      irq_n = 1'b0;
      if (!o[0]) begin
        edges_until(1, n);
        chk(n == D + 1, "R7 timed wake length", n, D + 1);
        chk(wake_irq, "R7 wake pulse", wake_irq, 1);
        irq_n = 1'b1;
      end else begin
        bad = 0;
        repeat (D + 3) begin
          step();
          if (cpu_clk_en) bad++;
        end
        chk(bad == 0, "R8 clock gated while pin low", bad, 0);
        chk(osc_en, "R6 oscillator restarted", osc_en, 1);
        irq_n = 1'b1;
        step();
        chk(cpu_clk_en && wake_irq, "R8 release on pin rise", cpu_clk_en, 1);
      end
    end

    // wake disabled
    step();
    repeat (G + 1) step();
    enter_pd();
    irq_wake_en = 1'b0;
    irq_n = 1'b0;
    bad = 0;
    repeat (5) begin
      step();
      if (osc_en) bad++;
    end
    chk(bad == 0, "R6 disabled interrupt ignored", bad, 0);
    irq_n = 1'b1;
    step();
    irq_wake_en = 1'b1;
    wake_ext_mode = 1'b0;
    irq_n = 1'b0;
    edges_until(1, n);
    chk(n == D + 1, "R6 enabled wake after disable", n, D + 1);
    irq_n = 1'b1;

    // software write of cold flag
    cold_wr = 1'b1; cold_wdata = 1'b0;
    step();
    cold_wr = 1'b0;
    chk(cold_flag == 1'b0, "R5 software clear", cold_flag, 0);

    // pin hold sweep
    for (int h = 1; h <= HOLD + 2; h++) begin
      ext_rst = 1'b1;
      first_hi = 0;
      for (int i = 1; i <= h + 3; i++) begin
        step();
        if (i == h) ext_rst = 1'b0;
        if (sys_rst && first_hi == 0) first_hi = i;
      end
      chk(first_hi == ((h >= HOLD) ? HOLD + 1 : 0), "R4 pin hold filter", first_hi,
          (h >= HOLD) ? HOLD + 1 : 0);
      chk(!sys_rst, "R4 release after pin low", sys_rst, 0);
    end
    chk(cold_flag == 1'b0, "R5 pin reset keeps flag", cold_flag, 0);

    // brown-out dip
    bod_ok = 1'b0;
    #1;
    chk(sys_rst && !cpu_clk_en && osc_en, "R3 immediate reset on bod loss", sys_rst, 1);
    @(negedge clk);
    repeat (2) step();
    bod_ok = 1'b1;
    edges_until(0, n);
    chk(n == D + 1, "R2 restart after bod", n, D + 1);
    chk(cold_flag == 1'b0, "R5 bod keeps flag", cold_flag, 0);

    // reset wake from power-down, long pin
    repeat (G + 1) step();
    enter_pd();
    ext_rst = 1'b1;
    step();
    chk(osc_en && sys_rst, "R9 reset wake starts osc", osc_en, 1);
    repeat (D + 3) step();
    chk(sys_rst && !cpu_clk_en, "R9 held while pin high", sys_rst, 1);
    ext_rst = 1'b0;
    step();
    chk(!sys_rst && cpu_clk_en, "R9 run after pin low", sys_rst, 0);

    // reset wake, short pin
    repeat (G + 1) step();
    enter_pd();
    ext_rst = 1'b1;
    step();
    step();
    ext_rst = 1'b0;
    edges_until(0, n);
    chk(n + 2 == D + 2, "R9 short pin still timed", n + 2, D + 2);

    // power-on loss
    por_ok = 1'b0;
    #1;
    chk(!osc_en && sys_rst && !cpu_clk_en, "R3 immediate reset on por loss", osc_en, 0);
    @(negedge clk);
    step();
    chk(cold_flag, "R5 por sets flag", cold_flag, 1);
    chk(!osc_en, "R1 osc off on por loss", osc_en, 0);
    por_ok = 1'b1;
    edges_until(0, n);
    chk(n == D + 2, "R2 cold start length", n, D + 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule